// File: doc/BRIEF.md
# System Board I/O Register Block

This block is the small set of byte-wide control and strap registers that a system board exposes on its I/O port space, plus a 32-bit parity-error window in memory space. A host bus presents an address, an access size, a write strobe, a read strobe and a data byte. The block decodes a fixed group of port offsets in the lowest 4 KiB of the address space and one 4-byte window at a parameterised base address.

Three registers hold state: a soft-reset register, a system control register and an I/O map type register. Each keeps only the bits its mask allows. The soft-reset bit and the map type bit drive output pins. Two ports return board strap bytes fixed by parameters. Several ports are write-only sinks or read-only constants. A write that requests a byte-order change is not carried out; it raises a sticky halt flag instead. Bits are numbered in reversed order: bit n of a byte carries the weight 1 << (7 - n).

Read data is registered. It is valid in the cycle after the read strobe and is zero in any cycle that does not follow a read. A read returns the register contents from before a write issued in the same cycle.

Top module: `sysio_regblk`

## Requirements
- R1: While `rst` is high at a clock edge, the soft-reset and system control registers are cleared, the map type register becomes 0x01, and `le_halt`, `size_err` and `rd_data` become 0. After reset, `srst_out` is 0 and `map_out` is 1.
- R2: A write to port 0x092 stores only the value 0x01 of the data byte (bit 7 in reversed numbering). `srst_out` equals the stored bit from the next cycle on. A read of 0x092 returns the stored byte.
- R3: A write to port 0x092 with 0x02 set (bit 6, byte-order request) sets `le_halt`. The flag stays set until reset. The 0x01 bit of the same write is still stored.
- R4: A write to port 0x81C stores the data ANDed with 0xF0 (bits 0 to 3). A read returns the stored value.
- R5: A write to port 0x850 stores only the value 0x01. `map_out` follows the stored bit from the next cycle on. A read returns the stored byte.
- R6: A read of port 0x80C returns parameter `EQUIP_STRAP`, and a read of port 0x852 returns `BOARD_ID`. Writes to either port change nothing.
- R7: A read of port 0x818 returns 0. Ports 0x808, 0x810, 0x812 and 0x814 read as 0, and writes to them change no register.
- R8: An access to the 4-byte window at `PAR_BASE` reads as 0, and a write to it changes nothing.
- R9: `size` encodes 0 = byte, 1 = half, 2 = word and 3 = reserved. A read or write to the parity window with any `size` other than 2 raises `size_err` for exactly the following cycle, and the read returns 0.
- R10: A read of any unmapped address returns 0, and a write to it changes nothing. Port offsets decode only when address bits above bit 11 are zero.
- R11: `rd_data` changes only one cycle after a read strobe. In a cycle not preceded by a read strobe, it is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | ADDR_W | Access address |
| size | input | 2 | Access size: 0 byte, 1 half, 2 word, 3 reserved |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| wdata | input | 8 | Write data byte |
| rd_data | output | DATA_W | Registered read data, valid one cycle after `rd_en` |
| srst_out | output | 1 | Soft-reset request pin |
| map_out | output | 1 | Non-contiguous I/O map indication |
| le_halt | output | 1 | Sticky flag for an unsupported byte-order request |
| size_err | output | 1 | One-cycle pulse for a non-word parity window access |

## Verification
The bench builds the block with `EQUIP_STRAP` = 0xA5 and `BOARD_ID` = 0x3C, leaving the parity base and widths at their defaults. With nonzero straps that differ from each other, a swapped strap decode, an unmasked strap or a strap leaking into a sink or keylock read shows up in the data. The two strap values also set bits both inside and outside the control mask, so reading the wrong port cannot go unnoticed. The default 32-bit address puts the window far above the 4 KiB port page, which lets the bench reach the check that high address bits suppress port decode.

// File: rtl/sysio_pkg.sv
package sysio_pkg;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_RSVD = 2'd3
  } acc_size_e;

  localparam int PORT_AW = 12;
  localparam int N_SINK  = 4;

  // reversed bit numbering: index n weighs 1 << (7 - n)
  function automatic logic [7:0] rev_bit(input int n);
    rev_bit = 8'd1 << (7 - n);
  endfunction

  function automatic logic [7:0] keep_bits(input logic [7:0] d, input logic [7:0] m);
    keep_bits = d & m;
  endfunction

  function automatic logic is_word(input logic [1:0] s);
    is_word = (s == SZ_WORD);
  endfunction

  localparam logic [7:0] SRST_MASK = rev_bit(7);
  localparam logic [7:0] LE_MASK   = rev_bit(6);
  localparam logic [7:0] CTL_MASK  = rev_bit(0) | rev_bit(1) | rev_bit(2) | rev_bit(3);
  localparam logic [7:0] MAP_MASK  = rev_bit(7);
  localparam logic [7:0] MAP_RST   = MAP_MASK;

  localparam logic [PORT_AW-1:0] A_SRST  = 12'h092;
  localparam logic [PORT_AW-1:0] A_EQUIP = 12'h80C;
  localparam logic [PORT_AW-1:0] A_KEY   = 12'h818;
  localparam logic [PORT_AW-1:0] A_CTL   = 12'h81C;
  localparam logic [PORT_AW-1:0] A_MAP   = 12'h850;
  localparam logic [PORT_AW-1:0] A_BOARD = 12'h852;
  localparam logic [PORT_AW-1:0] SINK_ADDR [N_SINK] = '{12'h808, 12'h810, 12'h812, 12'h814};

  typedef struct packed {
    logic srst;
    logic ctl;
    logic map;
    logic equip;
    logic board;
    logic keylock;
    logic sink;
    logic parity;
  } sel_t;

endpackage

// File: rtl/sysio_decode.sv
module sysio_decode
  import sysio_pkg::*;
#(
  parameter int                ADDR_W   = 32,
  parameter logic [ADDR_W-1:0] PAR_BASE = 32'hBFFF_EFF0
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [1:0]        size,
  output sel_t              sel,
  output logic              par_bad
);

  logic               low_page;
  logic [PORT_AW-1:0] off;
  logic [N_SINK-1:0]  sink_hit;

  assign low_page = (addr[ADDR_W-1:PORT_AW] == '0);
  assign off      = addr[PORT_AW-1:0];

  for (genvar g = 0; g < N_SINK; g++) begin : g_sink
    assign sink_hit[g] = low_page && (off == SINK_ADDR[g]);
  end

  always_comb begin
    sel         = '0;
    sel.srst    = low_page && (off == A_SRST);
    sel.ctl     = low_page && (off == A_CTL);
    sel.map     = low_page && (off == A_MAP);
    sel.equip   = low_page && (off == A_EQUIP);
    sel.board   = low_page && (off == A_BOARD);
    sel.keylock = low_page && (off == A_KEY);
    sel.sink    = |sink_hit;
    sel.parity  = (addr[ADDR_W-1:2] == PAR_BASE[ADDR_W-1:2]);
  end

  assign par_bad = sel.parity && !is_word(size);

endmodule

// File: rtl/sysio_mreg.sv
module sysio_mreg
  import sysio_pkg::*;
#(
  parameter logic [7:0] MASK    = 8'hFF,
  parameter logic [7:0] RST_VAL = 8'h00
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       we,
  input  logic [7:0] d,
  output logic [7:0] q
);

  always_ff @(posedge clk) begin
    if (rst)     q <= keep_bits(RST_VAL, MASK);
    else if (we) q <= keep_bits(d, MASK);
  end

endmodule

// File: rtl/sysio_regs.sv
module sysio_regs
  import sysio_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       wr_srst,
  input  logic       wr_ctl,
  input  logic       wr_map,
  input  logic [7:0] wdata,
  output logic [7:0] srst_q,
  output logic [7:0] ctl_q,
  output logic [7:0] map_q,
  output logic       halt_q
);

  logic le_req;

  sysio_mreg #(.MASK(SRST_MASK), .RST_VAL(8'h00)) u_srst (
    .clk(clk), .rst(rst), .we(wr_srst), .d(wdata), .q(srst_q)
  );

  sysio_mreg #(.MASK(CTL_MASK), .RST_VAL(8'h00)) u_ctl (
    .clk(clk), .rst(rst), .we(wr_ctl), .d(wdata), .q(ctl_q)
  );

  sysio_mreg #(.MASK(MAP_MASK), .RST_VAL(MAP_RST)) u_map (
    .clk(clk), .rst(rst), .we(wr_map), .d(wdata), .q(map_q)
  );

  assign le_req = wr_srst && (keep_bits(wdata, LE_MASK) != 8'h00);

  always_ff @(posedge clk) begin
    if (rst)         halt_q <= 1'b0;
    else if (le_req) halt_q <= 1'b1;
  end

endmodule

// File: rtl/sysio_rdmux.sv
module sysio_rdmux #(
  parameter int         DATA_W      = 32,
  parameter logic [7:0] EQUIP_STRAP = 8'h00,
  parameter logic [7:0] BOARD_ID    = 8'h00
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_en,
  input  logic              hit_srst,
  input  logic              hit_ctl,
  input  logic              hit_map,
  input  logic              hit_equip,
  input  logic              hit_board,
  input  logic [7:0]        srst_q,
  input  logic [7:0]        ctl_q,
  input  logic [7:0]        map_q,
  input  logic              size_bad,
  output logic [DATA_W-1:0] rd_data,
  output logic              size_err
);

  logic [7:0] byte_sel;

  // selects are mutually exclusive, so an AND-OR mux suffices
  always_comb begin
    byte_sel = ({8{hit_srst}}  & srst_q)
             | ({8{hit_ctl}}   & ctl_q)
             | ({8{hit_map}}   & map_q)
             | ({8{hit_equip}} & EQUIP_STRAP)
             | ({8{hit_board}} & BOARD_ID);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data  <= '0;
      size_err <= 1'b0;
    end else begin
      rd_data  <= rd_en ? DATA_W'(byte_sel) : '0;
      size_err <= size_bad;
    end
  end

endmodule

// File: rtl/sysio_regblk.sv
module sysio_regblk
  import sysio_pkg::*;
#(
  parameter int                ADDR_W      = 32,
  parameter int                DATA_W      = 32,
  parameter logic [ADDR_W-1:0] PAR_BASE    = 32'hBFFF_EFF0,
  parameter logic [7:0]        EQUIP_STRAP = 8'h00,
  parameter logic [7:0]        BOARD_ID    = 8'h00
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic [1:0]        size,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [7:0]        wdata,
  output logic [DATA_W-1:0] rd_data,
  output logic              srst_out,
  output logic              map_out,
  output logic              le_halt,
  output logic              size_err
);

  sel_t       sel;
  logic       par_bad;
  logic       ev_wr_srst;
  logic       ev_wr_ctl;
  logic       ev_wr_map;
  logic       ev_size_bad;
  logic [7:0] srst_q;
  logic [7:0] ctl_q;
  logic [7:0] map_q;

  sysio_decode #(.ADDR_W(ADDR_W), .PAR_BASE(PAR_BASE)) u_dec (
    .addr(addr), .size(size), .sel(sel), .par_bad(par_bad)
  );

  assign ev_wr_srst  = wr_en && sel.srst;
  assign ev_wr_ctl   = wr_en && sel.ctl;
  assign ev_wr_map   = wr_en && sel.map;
  assign ev_size_bad = (wr_en || rd_en) && par_bad;

  sysio_regs u_regs (
    .clk(clk), .rst(rst),
    .wr_srst(ev_wr_srst), .wr_ctl(ev_wr_ctl), .wr_map(ev_wr_map),
    .wdata(wdata),
    .srst_q(srst_q), .ctl_q(ctl_q), .map_q(map_q), .halt_q(le_halt)
  );

  sysio_rdmux #(.DATA_W(DATA_W), .EQUIP_STRAP(EQUIP_STRAP), .BOARD_ID(BOARD_ID)) u_rd (
    .clk(clk), .rst(rst), .rd_en(rd_en),
    .hit_srst(sel.srst), .hit_ctl(sel.ctl), .hit_map(sel.map),
    .hit_equip(sel.equip), .hit_board(sel.board),
    .srst_q(srst_q), .ctl_q(ctl_q), .map_q(map_q),
    .size_bad(ev_size_bad),
    .rd_data(rd_data), .size_err(size_err)
  );

  assign srst_out = (srst_q != 8'h00);
  assign map_out  = (map_q != 8'h00);

endmodule

// File: rtl/sysio_chk.sv
module sysio_chk
  import sysio_pkg::*;
#(
  parameter int         DATA_W      = 32,
  parameter logic [7:0] EQUIP_STRAP = 8'h00,
  parameter logic [7:0] BOARD_ID    = 8'h00
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_en,
  input logic              rd_en,
  input logic [7:0]        wdata,
  input logic [DATA_W-1:0] rd_data,
  input logic              srst_out,
  input logic              map_out,
  input logic              le_halt,
  input logic              size_err,
  input sel_t              sel,
  input logic              ev_size_bad
);

  a_r1_after_reset: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (map_out && !srst_out && !le_halt && !size_err && rd_data == '0));

  a_r2_srst_capture: assert property (@(posedge clk) disable iff (rst)
    (wr_en && sel.srst) |=> (srst_out == $past(wdata[0])));

  a_r2_srst_hold: assert property (@(posedge clk) disable iff (rst)
    !(wr_en && sel.srst) |=> $stable(srst_out));

  a_r3_halt_set: assert property (@(posedge clk) disable iff (rst)
    (wr_en && sel.srst && wdata[1]) |=> le_halt);

  a_r3_halt_sticky: assert property (@(posedge clk) disable iff (rst)
    le_halt |=> le_halt);

  a_r4_ctl_mask: assert property (@(posedge clk) disable iff (rst)
    (rd_en && sel.ctl) |=> (rd_data[3:0] == 4'h0 && rd_data[DATA_W-1:8] == '0));

  a_r5_map_capture: assert property (@(posedge clk) disable iff (rst)
    (wr_en && sel.map) |=> (map_out == $past(wdata[0])));

  a_r6_equip: assert property (@(posedge clk) disable iff (rst)
    (rd_en && sel.equip) |=> (rd_data == DATA_W'(EQUIP_STRAP)));

  a_r6_board: assert property (@(posedge clk) disable iff (rst)
    (rd_en && sel.board) |=> (rd_data == DATA_W'(BOARD_ID)));

  a_r7_quiet_ports: assert property (@(posedge clk) disable iff (rst)
    (rd_en && (sel.keylock || sel.sink)) |=> (rd_data == '0));

  a_r8_parity_zero: assert property (@(posedge clk) disable iff (rst)
    (rd_en && sel.parity) |=> (rd_data == '0));

  a_r9_err_raise: assert property (@(posedge clk) disable iff (rst)
    ev_size_bad |=> size_err);

  a_r9_err_quiet: assert property (@(posedge clk) disable iff (rst)
    !ev_size_bad |=> !size_err);

  a_r10_unmapped: assert property (@(posedge clk) disable iff (rst)
    (rd_en && sel == '0) |=> (rd_data == '0));

  a_r11_idle_zero: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> (rd_data == '0));

  a_r1_sel_onehot: assert property (@(posedge clk) disable iff (rst)
    $onehot0(sel));

endmodule

bind sysio_regblk sysio_chk #(
  .DATA_W(DATA_W), .EQUIP_STRAP(EQUIP_STRAP), .BOARD_ID(BOARD_ID)
) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .wdata(wdata),
  .rd_data(rd_data), .srst_out(srst_out), .map_out(map_out),
  .le_halt(le_halt), .size_err(size_err), .sel(sel), .ev_size_bad(ev_size_bad)
);

// File: tb/test_sysio_regblk.sv
module test_sysio_regblk;

  localparam logic [7:0]  EQ  = 8'hA5;
  localparam logic [7:0]  BD  = 8'h3C;
  localparam logic [31:0] PAR = 32'hBFFF_EFF0;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] addr = '0;
  logic [1:0]  size = 2'd0;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [7:0]  wdata = '0;
  logic [31:0] rd_data;
  logic        srst_out, map_out, le_halt, size_err;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  sysio_regblk #(.EQUIP_STRAP(EQ), .BOARD_ID(BD)) i_sysio_regblk (
    .clk(clk), .rst(rst), .addr(addr), .size(size), .wr_en(wr_en), .rd_en(rd_en),
    .wdata(wdata), .rd_data(rd_data), .srst_out(srst_out), .map_out(map_out),
    .le_halt(le_halt), .size_err(size_err)
  );

  // behavioural reference state
  int    m_srst, m_ctl, m_map, m_halt, exp_rd, exp_err;
  string rd_tag = "R1";
  bit    fresh = 1, armed = 0;

  function automatic bit in_win(input logic [31:0] a);
    return (a >= PAR) && (a < PAR + 4);
  endfunction

  function automatic int ref_read(input logic [31:0] a);
    if (in_win(a)) return 0;
    case (a)
      32'h092: return m_srst;
      32'h81C: return m_ctl;
      32'h850: return m_map;
      32'h80C: return int'(EQ);
      32'h852: return int'(BD);
      default: return 0;
    endcase
  endfunction

  function automatic string tag_of(input logic [31:0] a);
    if (in_win(a)) return "R8";
    case (a)
      32'h092: return "R2";
      32'h81C: return "R4";
      32'h850: return "R5";
      32'h80C, 32'h852: return "R6";
      32'h818, 32'h808, 32'h810, 32'h812, 32'h814: return "R7";
      default: return "R10";
    endcase
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_srst = 0; m_ctl = 0; m_map = 1; m_halt = 0;
      exp_rd = 0; exp_err = 0; rd_tag = "R1"; fresh = 1; armed = 1;
    end else begin
      exp_rd  = rd_en ? ref_read(addr) : 0;
      rd_tag  = rd_en ? tag_of(addr) : (fresh ? "R1" : "R11");
      exp_err = ((rd_en || wr_en) && in_win(addr) && size != 2'd2) ? 1 : 0;
      if (exp_err != 0 && rd_en) rd_tag = "R9";
      if (wr_en) begin
        case (addr)
          32'h092: begin
            m_srst = wdata % 2;
            if ((wdata / 2) % 2 == 1) m_halt = 1;
          end
          32'h81C: m_ctl = wdata - (wdata % 16);
          32'h850: m_map = wdata % 2;
          default: ;
        endcase
      end
      if (rd_en || wr_en) fresh = 0;
    end
  end

  task automatic chk(input string tag, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  // compare every cycle, away from the active edge
  always @(negedge clk) begin
    if (armed && !done) begin
      chk(rd_tag, "rd_data", int'(rd_data), exp_rd);
      chk(fresh ? "R1" : "R2", "srst_out", int'(srst_out), m_srst);
      chk(fresh ? "R1" : "R5", "map_out", int'(map_out), m_map);
      chk(fresh ? "R1" : "R3", "le_halt", int'(le_halt), m_halt);
      chk(fresh ? "R1" : "R9", "size_err", int'(size_err), exp_err);
    end
  end

  task automatic op(input bit w, input bit r, input logic [31:0] a,
                    input logic [1:0] s, input logic [7:0] d);
    @(negedge clk);
    wr_en = w; rd_en = r; addr = a; size = s; wdata = d;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) op(0, 0, 32'h0, 2'd0, 8'h00);
  endtask

  task automatic summary();
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    summary();
  end

  localparam logic [31:0] PICK [14] = '{32'h092, 32'h81C, 32'h850, 32'h80C, 32'h852,
    32'h818, 32'h808, 32'h810, 32'h812, 32'h814, 32'hBFFF_EFF0, 32'hBFFF_EFF3,
    32'h093, 32'h0001_0092};

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset contents
    op(0, 1, 32'h092, 0, 0); op(0, 1, 32'h81C, 0, 0); op(0, 1, 32'h850, 0, 0); idle(1);
    // R2 soft reset bit only
    op(1, 0, 32'h092, 0, 8'h01); op(0, 1, 32'h092, 0, 0);
    op(1, 0, 32'h092, 0, 8'h00); op(0, 1, 32'h092, 0, 0);
    op(1, 0, 32'h092, 0, 8'hFD); op(0, 1, 32'h092, 0, 0); idle(1);
    // R4 control mask
    op(1, 0, 32'h81C, 0, 8'hFF); op(0, 1, 32'h81C, 0, 0);
    op(1, 0, 32'h81C, 0, 8'h5A); op(0, 1, 32'h81C, 0, 0);
    // R5 map type
    op(1, 0, 32'h850, 0, 8'h00); op(0, 1, 32'h850, 0, 0);
    op(1, 0, 32'h850, 0, 8'hFE); op(0, 1, 32'h850, 0, 0);
    op(1, 0, 32'h850, 0, 8'h01); op(0, 1, 32'h850, 0, 0);
    // R6 straps, writes ignored
    op(0, 1, 32'h80C, 0, 0); op(0, 1, 32'h852, 0, 0);
    op(1, 0, 32'h80C, 0, 8'h00); op(1, 0, 32'h852, 0, 8'hFF);
    op(0, 1, 32'h80C, 0, 0); op(0, 1, 32'h852, 0, 0);
    // R7 keylock and sinks
    for (int i = 5; i < 10; i++) op(1, 0, PICK[i], 0, 8'hFF);
    for (int i = 5; i < 10; i++) op(0, 1, PICK[i], 0, 0);
    op(0, 1, 32'h81C, 0, 0); op(0, 1, 32'h092, 0, 0); op(0, 1, 32'h850, 0, 0);
    // R8 / R9 parity window
    op(0, 1, PAR, 2, 0); op(1, 0, PAR, 2, 8'hFF); op(0, 1, PAR + 2, 2, 0);
    op(0, 1, PAR, 0, 0); idle(1); op(1, 0, PAR + 1, 1, 8'h11); idle(1);
    op(0, 1, PAR + 3, 3, 0); op(0, 1, PAR, 0, 0); idle(2);
    // R10 unmapped, high address bits block port decode
    op(0, 1, 32'h900, 0, 0); op(0, 1, 32'h093, 0, 0);
    op(1, 0, 32'h0001_081C, 0, 8'h00); op(1, 0, 32'h093, 0, 8'hFF);
    op(0, 1, 32'h0001_081C, 0, 0); op(0, 1, 32'h81C, 0, 0);
    // R11 back-to-back reads then idle
    op(0, 1, 32'h80C, 0, 0); op(0, 1, 32'h852, 0, 0); idle(3);
    // mixed traffic
    for (int i = 0; i < 400; i++)
      op(1'($urandom % 2), 1'($urandom % 2), PICK[$urandom % 14],
         2'($urandom % 4), 8'($urandom));
    idle(2);
    // R3 sticky halt, cleared only by reset
    @(negedge clk); rst = 1'b1; @(negedge clk); rst = 1'b0;
    op(1, 0, 32'h092, 0, 8'h03); op(0, 1, 32'h092, 0, 0);
    op(1, 0, 32'h092, 0, 8'h00); idle(3);
    @(negedge clk); rst = 1'b1; @(negedge clk); rst = 1'b0;
    idle(3);
    summary();
  end

endmodule